// File: doc/BRIEF.md
# Temperature Compensation Interpolator

This block turns an 8-bit temperature code into five correction values: a fine gain for each of two signal channels, a fine offset for each of the same two channels, and an offset for a third index channel. The corrections come from a breakpoint table of 2 to `NUM_ENTRIES` entries. Each entry pairs a temperature breakpoint with five correction bytes. The block finds the two breakpoints that bracket the temperature and interpolates linearly between their stored values. It uses one shared sequential divider and works through the five values in turn.

Each interpolated gain and offset for the two main channels is added to its own trim input, which comes from a user register or an automatic control loop. The sum saturates to the 8-bit range. With compensation disabled, the fine values are the trim inputs themselves. The block recomputes whenever the temperature code or the enable changes. A one-cycle strobe marks the moment all five results are replaced together. The table is presented on a flat input vector that some other logic keeps stable.

Top module: `tc_interp`

## Requirements
- R1: During and after reset the stored interpolated values are zero and the done strobe is low: with the enable high and trims at zero, every fine output reads 0 until the first computation completes.
- R2: Entry k of `lut_i` occupies bits [48k+47:48k]. Byte 0 (lowest) is the breakpoint; bytes 1 to 5 are gain A, gain B, offset A, offset B and offset Z. Gain bytes are unsigned and offset bytes are two's complement.
- R3: The table ends at the first entry whose breakpoint is 255; later entries have no effect on any output. Otherwise the bracketing pair is the last valid entry whose breakpoint is less than or equal to the temperature, together with its successor.
- R4: When the temperature equals a valid breakpoint, the interpolated values are exactly that entry's stored bytes.
- R5: Between breakpoints each value is y0 + (y1 - y0) * (t - b0) / (b1 - b0), with the quotient truncated toward zero.
- R6: With no 255 terminator in the table, a temperature above the last entry's breakpoint yields the last entry's values.
- R7: When enabled, each fine gain is the interpolated gain plus its unsigned gain trim, clamped to 255.
- R8: When enabled, each main-channel fine offset is the interpolated offset plus its signed offset trim, clamped to the range -128 to 127.
- R9: The index-channel offset output is the interpolated Z offset with no trim added and no gain output.
- R10: With the enable low, the fine gains and fine offsets equal their trim inputs and the Z offset is 0, from the same cycle the enable falls.
- R11: A change of temperature or enable starts a new computation and abandons any computation in progress. Outputs keep their previous interpolated values until a single one-cycle done pulse, at which point all five are replaced together.
- R12: A trim input change alters the fine outputs at once, without starting a computation or producing a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_en_i | input | 1 | Temperature compensation enable |
| temp_i | input | 8 | Temperature code, 0 to 255 |
| lut_i | input | 48*NUM_ENTRIES | Breakpoint table, six bytes per entry |
| dgain_a_i | input | 8 | Gain trim, channel A (unsigned) |
| dgain_b_i | input | 8 | Gain trim, channel B (unsigned) |
| dofs_a_i | input | 8 | Offset trim, channel A (signed) |
| dofs_b_i | input | 8 | Offset trim, channel B (signed) |
| fgain_a_o | output | 8 | Fine gain, channel A |
| fgain_b_o | output | 8 | Fine gain, channel B |
| fofs_a_o | output | 8 | Fine offset, channel A |
| fofs_b_o | output | 8 | Fine offset, channel B |
| fofs_z_o | output | 8 | Interpolated offset, index channel |
| done_o | output | 1 | One-cycle strobe when new results are in place |

## Verification
The bench builds the block with the default `NUM_ENTRIES` of 16. With 16 entries it can load a table that ends at entry 3 and still has twelve entries of deliberately conflicting content behind the terminator, which shows that entries after the terminator are ignored. It can also load a table that fills all sixteen entries with no terminator, which reaches the upper-end clamp and the largest search depth. Divider truncation, saturation at both ends of the signed range and at the top of the unsigned range, and an abort in the middle of a computation are all checked at these sizes.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int BYTE_W   = 8;
    localparam int FIELDS   = 6;   // breakpoint + five corrections
    localparam int NCH      = 5;   // corrections per entry
    localparam int ENTRY_W  = FIELDS * BYTE_W;
    localparam int VAL_W    = NCH * BYTE_W;
    localparam int QUOT_W   = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_DONE
    } tc_state_e;

    typedef struct packed {
        byte_t gain_a;
        byte_t gain_b;
        byte_t ofs_a;
        byte_t ofs_b;
        byte_t ofs_z;
    } tc_corr_t;

    // unsigned add, clamped at the top
    function automatic byte_t sat_u8(input byte_t a, input byte_t b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W] ? {BYTE_W{1'b1}} : s[BYTE_W-1:0];
    endfunction

    // two's complement add, clamped at both ends
    function automatic byte_t sat_s8(input byte_t a, input byte_t b);
        logic signed [BYTE_W:0] s;
        s = $signed({a[BYTE_W-1], a}) + $signed({b[BYTE_W-1], b});
        if (s > 9'sd127)       return 8'h7F;
        else if (s < -9'sd128) return 8'h80;
        else                   return s[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tc_seg_search.sv
module tc_seg_search
    import tc_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES*BYTE_W-1:0] bp_i,
    input  byte_t                         temp_i,
    output logic [IW-1:0]                 lo_idx_o,
    output logic [IW-1:0]                 hi_idx_o,
    output logic                          exact_o,
    output byte_t                         bp_lo_o,
    output byte_t                         bp_hi_o
);

    logic [IW-1:0] idx;
    logic [IW-1:0] last;
    logic          found;
    logic          stop;

    // walk the table up to the terminator, keep the last breakpoint <= temp
    always_comb begin
        stop  = 1'b0;
        found = 1'b0;
        idx   = '0;
        last  = IW'(NUM_ENTRIES - 1);
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (!stop) begin
                if (bp_i[k*BYTE_W +: BYTE_W] <= temp_i) begin
                    idx   = IW'(k);
                    found = 1'b1;
                end
                if (bp_i[k*BYTE_W +: BYTE_W] == 8'hFF) begin
                    stop = 1'b1;
                    last = IW'(k);
                end
            end
        end
    end

    assign bp_lo_o  = bp_i[int'(idx)*BYTE_W +: BYTE_W];
    assign exact_o  = !found || (bp_lo_o == temp_i) || (idx == last);
    assign lo_idx_o = idx;
    assign hi_idx_o = exact_o ? idx : idx + 1'b1;
    assign bp_hi_o  = bp_i[int'(hi_idx_o)*BYTE_W +: BYTE_W];

endmodule

// File: rtl/tc_divider.sv
module tc_divider #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 8,
    localparam int CW   = $clog2(NUM_W + 1),
    localparam int PW   = NUM_W + DEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic             done_q;

    logic [DEN_W:0]   rem_sh;
    logic             take;
    logic [DEN_W:0]   rem_nx;

    // one restoring step: shift in the next dividend bit, subtract if it fits
    always_comb begin
        rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        take   = (rem_sh >= {1'b0, den_q});
        rem_nx = take ? rem_sh - {1'b0, den_q} : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            quo_q  <= num_i;
            num_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CW'(NUM_W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= rem_nx;
            quo_q  <= {quo_q[NUM_W-2:0], take};
            cnt_q  <= cnt_q - 1'b1;
            busy_q <= (cnt_q != CW'(1));
            done_q <= (cnt_q == CW'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign quot_o = quo_q;

    logic [PW-1:0] chk_recon;
    assign chk_recon = PW'(quo_q) * PW'(den_q) + PW'(rem_q);

    // R5
    div_exact_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (chk_recon == PW'(num_q)) && (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/tc_interp_ctrl.sv
module tc_interp_ctrl
    import tc_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW     = $clog2(NUM_ENTRIES),
    localparam int VALS_W = NUM_ENTRIES * VAL_W,
    localparam int RW     = QUOT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_t             temp_i,
    input  logic              en_i,
    input  logic [VALS_W-1:0] vals_i,
    input  logic [IW-1:0]     lo_idx_i,
    input  logic [IW-1:0]     hi_idx_i,
    input  logic              exact_i,
    input  byte_t             bp_lo_i,
    input  byte_t             bp_hi_i,
    output byte_t             tcap_o,
    output logic              div_start_o,
    output logic [QUOT_W-1:0] div_num_o,
    output byte_t             div_den_o,
    input  logic              div_done_i,
    input  logic [QUOT_W-1:0] div_quot_i,
    output tc_corr_t          corr_o,
    output logic              done_o
);

    localparam logic [2:0] CH_LAST = 3'(NCH - 1);

    tc_state_e state_q;
    logic [2:0] ch_q;
    byte_t      tcap_q;
    byte_t      t_q;
    logic       en_q;
    logic       first_q;
    byte_t      scratch_q [NCH];
    tc_corr_t   corr_q;
    logic       done_q;
    logic                 neg_q;
    logic signed [RW-1:0] y0e_q;
    logic signed [RW-1:0] y1e_q;

    logic                 req;
    byte_t                y0;
    byte_t                y1;
    logic                 sgn;
    logic signed [RW-1:0] y0x;
    logic signed [RW-1:0] y1x;
    logic signed [RW-1:0] diff;
    logic signed [RW-1:0] mag;
    logic signed [RW-1:0] res_x;

    assign req = first_q || (temp_i != t_q) || (en_i != en_q);

    // endpoint values and the numerator for the current channel
    always_comb begin
        y0   = vals_i[(int'(lo_idx_i)*NCH + int'(ch_q))*BYTE_W +: BYTE_W];
        y1   = vals_i[(int'(hi_idx_i)*NCH + int'(ch_q))*BYTE_W +: BYTE_W];
        sgn  = (ch_q >= 3'd2);
        y0x  = sgn ? RW'($signed(y0)) : $signed(RW'(y0));
        y1x  = sgn ? RW'($signed(y1)) : $signed(RW'(y1));
        diff = y1x - y0x;
        mag  = (diff < 0) ? -diff : diff;
        res_x = neg_q ? y0e_q - $signed(RW'(div_quot_i))
                      : y0e_q + $signed(RW'(div_quot_i));
    end

    assign div_num_o   = QUOT_W'(mag[BYTE_W-1:0]) * QUOT_W'(tcap_q - bp_lo_i);
    assign div_den_o   = bp_hi_i - bp_lo_i;
    assign div_start_o = (state_q == ST_SETUP) && !req && !exact_i;

    always_ff @(posedge clk) begin
        t_q  <= temp_i;
        en_q <= en_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            tcap_q  <= '0;
            first_q <= 1'b1;
            corr_q  <= '0;
            done_q  <= 1'b0;
            neg_q   <= 1'b0;
            y0e_q   <= '0;
            y1e_q   <= '0;
            for (int c = 0; c < NCH; c++) scratch_q[c] <= '0;
        end else begin
            first_q <= 1'b0;
            done_q  <= 1'b0;
            if (req) begin
                tcap_q  <= temp_i;
                ch_q    <= '0;
                state_q <= ST_SETUP;
            end else begin
                case (state_q)
                    ST_SETUP: begin
                        if (exact_i) begin
                            scratch_q[ch_q] <= y0;
                            if (ch_q == CH_LAST) state_q <= ST_DONE;
                            else ch_q <= ch_q + 1'b1;
                        end else begin
                            y0e_q   <= y0x;
                            y1e_q   <= y1x;
                            neg_q   <= (diff < 0);
                            state_q <= ST_WAIT;
                        end
                    end
                    ST_WAIT: begin
                        if (div_done_i) begin
                            scratch_q[ch_q] <= res_x[BYTE_W-1:0];
                            if (ch_q == CH_LAST) begin
                                state_q <= ST_DONE;
                            end else begin
                                ch_q    <= ch_q + 1'b1;
                                state_q <= ST_SETUP;
                            end
                        end
                    end
                    ST_DONE: begin
                        corr_q  <= '{gain_a: scratch_q[0], gain_b: scratch_q[1],
                                     ofs_a: scratch_q[2], ofs_b: scratch_q[3],
                                     ofs_z: scratch_q[4]};
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign tcap_o = tcap_q;
    assign corr_o = corr_q;
    assign done_o = done_q;

    // R3
    bracket_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP && !exact_i) |-> (bp_lo_i < tcap_q) && (bp_hi_i > tcap_q));

    // R5
    interp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && div_done_i) |->
            (res_x >= (neg_q ? y1e_q : y0e_q)) && (res_x <= (neg_q ? y0e_q : y1e_q)));

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(temp_i) |=> (state_q == ST_SETUP));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/tc_trim_sum.sv
module tc_trim_sum
    import tc_pkg::*;
(
    input  logic            en_i,
    input  tc_corr_t        corr_i,
    input  logic [1:0][7:0] dgain_i,
    input  logic [1:0][7:0] dofs_i,
    output logic [1:0][7:0] fgain_o,
    output logic [1:0][7:0] fofs_o,
    output byte_t           fofs_z_o
);

    logic [1:0][7:0] ip_gain;
    logic [1:0][7:0] ip_ofs;

    assign ip_gain = {corr_i.gain_b, corr_i.gain_a};
    assign ip_ofs  = {corr_i.ofs_b, corr_i.ofs_a};

    for (genvar c = 0; c < 2; c++) begin : g_chan
        assign fgain_o[c] = en_i ? sat_u8(ip_gain[c], dgain_i[c]) : dgain_i[c];
        assign fofs_o[c]  = en_i ? sat_s8(ip_ofs[c], dofs_i[c])   : dofs_i[c];
    end

    assign fofs_z_o = en_i ? corr_i.ofs_z : '0;

endmodule

// File: rtl/tc_interp.sv
module tc_interp
    import tc_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IW     = $clog2(NUM_ENTRIES),
    localparam int LUT_W  = NUM_ENTRIES * ENTRY_W,
    localparam int BPS_W  = NUM_ENTRIES * BYTE_W,
    localparam int VALS_W = NUM_ENTRIES * VAL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             comp_en_i,
    input  logic [7:0]       temp_i,
    input  logic [LUT_W-1:0] lut_i,
    input  logic [7:0]       dgain_a_i,
    input  logic [7:0]       dgain_b_i,
    input  logic [7:0]       dofs_a_i,
    input  logic [7:0]       dofs_b_i,
    output logic [7:0]       fgain_a_o,
    output logic [7:0]       fgain_b_o,
    output logic [7:0]       fofs_a_o,
    output logic [7:0]       fofs_b_o,
    output logic [7:0]       fofs_z_o,
    output logic             done_o
);

    logic [BPS_W-1:0]  bp_vec;
    logic [VALS_W-1:0] val_vec;

    for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_split
        assign bp_vec[k*BYTE_W +: BYTE_W] = lut_i[k*ENTRY_W +: BYTE_W];
        assign val_vec[k*VAL_W +: VAL_W]  = lut_i[k*ENTRY_W + BYTE_W +: VAL_W];
    end

    byte_t             tcap;
    logic [IW-1:0]     lo_idx;
    logic [IW-1:0]     hi_idx;
    logic              exact;
    byte_t             bp_lo;
    byte_t             bp_hi;
    logic              div_start;
    logic [QUOT_W-1:0] div_num;
    byte_t             div_den;
    logic              div_done;
    logic [QUOT_W-1:0] div_quot;
    tc_corr_t          corr;
    logic [1:0][7:0]   fgain;
    logic [1:0][7:0]   fofs;

    tc_seg_search #(.NUM_ENTRIES(NUM_ENTRIES)) u_search (
        .bp_i     (bp_vec),
        .temp_i   (tcap),
        .lo_idx_o (lo_idx),
        .hi_idx_o (hi_idx),
        .exact_o  (exact),
        .bp_lo_o  (bp_lo),
        .bp_hi_o  (bp_hi)
    );

    tc_divider #(.NUM_W(QUOT_W), .DEN_W(BYTE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    tc_interp_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .temp_i      (temp_i),
        .en_i        (comp_en_i),
        .vals_i      (val_vec),
        .lo_idx_i    (lo_idx),
        .hi_idx_i    (hi_idx),
        .exact_i     (exact),
        .bp_lo_i     (bp_lo),
        .bp_hi_i     (bp_hi),
        .tcap_o      (tcap),
        .div_start_o (div_start),
        .div_num_o   (div_num),
        .div_den_o   (div_den),
        .div_done_i  (div_done),
        .div_quot_i  (div_quot),
        .corr_o      (corr),
        .done_o      (done_o)
    );

    tc_trim_sum u_trim (
        .en_i     (comp_en_i),
        .corr_i   (corr),
        .dgain_i  ({dgain_b_i, dgain_a_i}),
        .dofs_i   ({dofs_b_i, dofs_a_i}),
        .fgain_o  (fgain),
        .fofs_o   (fofs),
        .fofs_z_o (fofs_z_o)
    );

    assign fgain_a_o = fgain[0];
    assign fgain_b_o = fgain[1];
    assign fofs_a_o  = fofs[0];
    assign fofs_b_o  = fofs[1];

    // R7
    gain_floor_chk: assert property (@(posedge clk) disable iff (rst)
        comp_en_i |-> (fgain_a_o >= dgain_a_i) && (fgain_b_o >= dgain_b_i));

endmodule

// File: tb/tc_interp_tb.sv
`timescale 1ns/1ps
module tc_interp_tb;

    localparam int N     = 16;
    localparam int LUT_W = N * 48;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en;
    logic [7:0]       temp;
    logic [LUT_W-1:0] lut;
    logic [7:0]       dga, dgb, doa, dob;
    logic [7:0]       fga, fgb, foa, fob, foz;
    logic             done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] tbl [N][6];

    always #2.5 clk = ~clk;

    tc_interp #(.NUM_ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst), .comp_en_i(en), .temp_i(temp), .lut_i(lut),
        .dgain_a_i(dga), .dgain_b_i(dgb), .dofs_a_i(doa), .dofs_b_i(dob),
        .fgain_a_o(fga), .fgain_b_o(fgb), .fofs_a_o(foa), .fofs_b_o(fob),
        .fofs_z_o(foz), .done_o(done)
    );

    typedef struct packed {
        logic [7:0] t;
        logic       e;
        logic [7:0] ga;
        logic [7:0] gb;
        logic [7:0] oa;
        logic [7:0] ob;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'd33,  1'b1, 8'd0,   8'd0,   8'd0,   8'd0},
        '{8'd50,  1'b1, 8'd3,   8'd9,   8'hFE,  8'd4},
        '{8'd100, 1'b1, 8'd0,   8'd0,   8'd0,   8'd0},
        '{8'd140, 1'b1, 8'd20,  8'd1,   8'd7,   8'hF0},
        '{8'd180, 1'b1, 8'd0,   8'd0,   8'd0,   8'd0},
        '{8'd210, 1'b1, 8'd11,  8'd0,   8'hF6,  8'd2},
        '{8'd255, 1'b1, 8'd250, 8'd10,  8'd5,   8'hFF},
        '{8'd60,  1'b0, 8'd42,  8'd17,  8'h81,  8'd66}
    };

    function automatic logic [7:0] satu(input logic [7:0] a, input logic [7:0] b);
        int s = int'(a) + int'(b);
        return (s > 255) ? 8'hFF : 8'(s);
    endfunction

    function automatic logic [7:0] sats(input logic [7:0] a, input logic [7:0] b);
        int s = int'($signed(a)) + int'($signed(b));
        if (s > 127) return 8'h7F;
        if (s < -128) return 8'h80;
        return 8'(s);
    endfunction

    // reference interpolation written from the requirements
    function automatic logic [7:0] model(input int ch, input logic [7:0] t);
        int last = N - 1;
        int i = -1;
        int y0, y1, b0, b1;
        for (int k = 0; k < N; k++) begin
            if (tbl[k][0] == 8'hFF) begin last = k; break; end
        end
        for (int k = 0; k <= last; k++) if (tbl[k][0] <= t) i = k;
        if (i < 0) return tbl[0][ch+1];
        if (tbl[i][0] == t || i == last) return tbl[i][ch+1];
        y0 = (ch >= 2) ? int'($signed(tbl[i][ch+1]))   : int'(tbl[i][ch+1]);
        y1 = (ch >= 2) ? int'($signed(tbl[i+1][ch+1])) : int'(tbl[i+1][ch+1]);
        b0 = int'(tbl[i][0]);
        b1 = int'(tbl[i+1][0]);
        return 8'(y0 + ((y1 - y0) * (int'(t) - b0)) / (b1 - b0));
    endfunction

    task automatic pack_lut();
        for (int k = 0; k < N; k++)
            for (int j = 0; j < 6; j++)
                lut[(k*6+j)*8 +: 8] = tbl[k][j];
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (n < 1000) begin
            @(negedge clk);
            if (done) break;
            n++;
        end
        n_chk++;
        if (n >= 1000) begin
            n_fail++;
            $display("FAIL R11: actual no done expected done pulse");
        end
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        int seen = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(tag, 8'(seen), 8'd0);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " fgain_a"}, fga, en ? satu(model(0, temp), dga) : dga);
        chk({tag, " fgain_b"}, fgb, en ? satu(model(1, temp), dgb) : dgb);
        chk({tag, " fofs_a"},  foa, en ? sats(model(2, temp), doa) : doa);
        chk({tag, " fofs_b"},  fob, en ? sats(model(3, temp), dob) : dob);
        chk({tag, " fofs_z"},  foz, en ? model(4, temp) : 8'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // table A: terminator at entry 3, conflicting entries after it
        tbl[0] = '{8'd0,   8'd100, 8'd50,  8'd10,  8'hEC, 8'd0};
        tbl[1] = '{8'd100, 8'd200, 8'd40,  8'hE2,  8'd20,  8'd5};
        tbl[2] = '{8'd180, 8'd150, 8'd60,  8'd0,   8'd0,   8'hF6};
        tbl[3] = '{8'd255, 8'd10,  8'd255, 8'd127, 8'h80,  8'd60};
        for (int k = 4; k < N; k++) begin
            tbl[k][0] = 8'(40 + k);
            for (int j = 1; j < 6; j++) tbl[k][j] = 8'hAA;
        end
        pack_lut();
        en = 1'b1; temp = 8'd0;
        dga = 8'd0; dgb = 8'd0; doa = 8'd0; dob = 8'd0;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 done in reset", {7'd0, done}, 8'd0);
        chk("R1 fgain_a in reset", fga, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fofs_z after reset", foz, 8'd0);
        chk("R1 fofs_a after reset", foa, 8'd0);
        wait_done();
        // R4: temperature 0 hits the first breakpoint exactly
        chk("R4 exact bp0 fgain_a", fga, 8'd100);
        check_all("R2 R4 t0");

        // main vectors: R2 R3 R4 R5 R7 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            temp = VECS[v].t; en = VECS[v].e;
            dga = VECS[v].ga; dgb = VECS[v].gb; doa = VECS[v].oa; dob = VECS[v].ob;
            wait_done();
            check_all("R5 R7 R8 R9 R10 vector");
        end

        // R5: truncation toward zero, hand values at t=33
        temp = 8'd33; en = 1'b1; dga = 8'd0; dgb = 8'd0; doa = 8'd0; dob = 8'd0;
        wait_done();
        chk("R5 fgain_a t33", fga, 8'd133);
        chk("R5 fofs_a t33 toward zero", foa, 8'hFD);

        // R10: disable takes effect in the same cycle
        dga = 8'd7; en = 1'b0;
        #1;
        chk("R10 fgain_a equals trim", fga, 8'd7);
        chk("R10 fofs_z zero", foz, 8'd0);
        wait_done();
        en = 1'b1;
        wait_done();

        // R12: trim change without recompute
        dga = 8'd10;
        #1;
        chk("R12 fgain_a follows trim", fga, 8'd143);
        expect_quiet(40, "R12 no done on trim change");

        // R11: abort mid computation, old values held until done
        temp = 8'd210;
        repeat (5) @(negedge clk);
        chk("R11 no early done", {7'd0, done}, 8'd0);
        chk("R11 old value held", fga, 8'd143);
        temp = 8'd255;
        wait_done();
        chk("R11 result of final temp", fga, 8'd20);
        expect_quiet(150, "R11 single done");

        // R3: junk after terminator ignored, hand value at t=210
        temp = 8'd210;
        wait_done();
        chk("R3 fgain_a t210", fga, 8'd104);

        // R7 R8: saturation at t=255
        temp = 8'd255;
        wait_done();
        dgb = 8'd10; doa = 8'd5; dob = 8'hFF;
        #1;
        chk("R7 gain clamps at 255", fgb, 8'hFF);
        chk("R8 offset clamps at 127", foa, 8'h7F);
        chk("R8 offset clamps at -128", fob, 8'h80);
        chk("R9 fofs_z untrimmed", foz, 8'd60);

        // R6: full table without terminator
        for (int k = 0; k < N; k++) begin
            tbl[k] = '{8'(k*10), 8'(k*10), 8'(255 - k*10),
                       8'(k*8 - 60), 8'(60 - k*8), 8'(k*3)};
        end
        pack_lut();
        dga = 8'd0; dgb = 8'd0; doa = 8'd0; dob = 8'd0;
        temp = 8'd200;
        wait_done();
        chk("R6 above last bp", fga, 8'd150);
        check_all("R6 t200");
        temp = 8'd155;
        wait_done();
        check_all("R6 t155");
        temp = 8'd75;
        wait_done();
        chk("R5 table B t75", fga, 8'd75);
        check_all("R5 table B t75");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule